// File: doc/BRIEF.md
# Flash Status Register Read Controller

This block is the read-mode and status-byte logic of a parallel NOR-style flash device. It decodes commands written on a simple one-cycle command port. It also keeps an 8-bit status byte, built from live busy and suspend inputs and from sticky error flags. A 16-bit read path either passes array data through or returns the status byte.

A program, erase or lock command moves the read path into status mode with no further command. The path stays there until a read-array command is written. The status byte is not sampled on every read. It is captured on chosen edges of the active-low chip-enable, output-enable and address-valid strobes, and which edges count depends on whether the host reads asynchronously or in synchronous bursts. The memory array and the embedded algorithms are outside the block. Plain busy, suspend and fail inputs stand in for them.

Top module: `fsr_read_ctrl`

## Requirements
- R1: After reset, the read path is in array mode, every sticky error bit is clear and the captured status is 0x80. With busy low, a status read therefore returns 0x0080.
- R2: In status mode with the bus enabled, dq_o carries {8'h00, status}: the status byte is on bits 7..0 and bits 15..8 are zero.
- R3: Command codes 0xB0 (program), 0xB1 (erase) and 0xB2 (lock) switch the read path to status mode. Code 0xA0 (read array) switches it back, and array mode returns arr_data on dq_o.
- R4: Command code 0xA1 (read status) switches the read path to status mode.
- R5: Status bit 7 is the inverse of busy, bit 6 follows ers_susp and bit 2 follows prg_susp, each taken at the moment of capture. Bit 0 is always 0.
- R6: The error pulses are sticky. err_erase sets bit 5, err_prog sets bit 4, err_volt sets bit 3, err_lock sets bit 1, and err_seq sets bits 5 and 4 together. These bits stay set until command 0xA2 (clear status) clears bits 5..1. That command does not change the read mode.
- R7: With sync_mode low, the status is captured on the first falling edge of ce_n or oe_n after both were high. A later falling edge within the same access does not refresh it.
- R8: With sync_mode high, the status is captured only on a falling edge of ce_n or of adv_n. Otherwise the same captured word is returned on every cycle of the burst.
- R9: With sync_mode low and in status mode, only the word offset present at capture returns status. Any other word_off value returns 0x0000.
- R10: dq_en is low whenever ce_n or oe_n is high.
- R11: Command codes outside the set above leave the read mode and the status unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_wr | input | 1 | One-cycle command write strobe |
| cmd_code | input | 8 | Command code written with cmd_wr |
| busy | input | 1 | Embedded operation in progress |
| ers_susp | input | 1 | Erase suspend in effect |
| prg_susp | input | 1 | Program suspend in effect |
| err_erase | input | 1 | Erase failure pulse |
| err_prog | input | 1 | Program failure pulse |
| err_seq | input | 1 | Command sequence error pulse |
| err_volt | input | 1 | Supply voltage error pulse |
| err_lock | input | 1 | Locked-block error pulse |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| adv_n | input | 1 | Address valid, active low |
| sync_mode | input | 1 | 1 = synchronous burst reads, 0 = asynchronous reads |
| word_off | input | 2 | Word offset within the page |
| arr_data | input | 16 | Array word returned in array mode |
| dq_o | output | 16 | Read data |
| dq_en | output | 1 | Read data drive enable (0 = bus released) |

## Verification
A command, an error pulse or a strobe edge is registered on the rising clock edge that samples it. The mode, the sticky bits and the captured status therefore show on dq_o one cycle after the inputs are applied. dq_en follows ce_n and oe_n with no register in the path. The bench drives each vector on the falling clock edge and compares on the next falling edge, after exactly one rising edge. At that point the inputs are still held, so the word-offset masking and dq_en are compared against the same inputs that produced the captured value.

// File: rtl/fsr_pkg.sv
package fsr_pkg;

    typedef enum logic {
        MODE_ARRAY  = 1'b0,
        MODE_STATUS = 1'b1
    } rd_mode_e;

    localparam int unsigned SR_W = 8;

    localparam logic [7:0] CMD_RD_ARRAY  = 8'hA0;
    localparam logic [7:0] CMD_RD_STATUS = 8'hA1;
    localparam logic [7:0] CMD_CLR_STAT  = 8'hA2;
    localparam logic [7:0] CMD_PROGRAM   = 8'hB0;
    localparam logic [7:0] CMD_ERASE     = 8'hB1;
    localparam logic [7:0] CMD_LOCK      = 8'hB2;

    localparam logic [SR_W-1:0] SR_RESET = 8'h80;

    // bit positions inside the status byte
    localparam int unsigned BIT_READY   = 7;
    localparam int unsigned BIT_ESUSP   = 6;
    localparam int unsigned BIT_EFAIL   = 5;
    localparam int unsigned BIT_PFAIL   = 4;
    localparam int unsigned BIT_VOLT    = 3;
    localparam int unsigned BIT_PSUSP   = 2;
    localparam int unsigned BIT_LOCKERR = 1;

    localparam logic [SR_W-1:0] STICKY_MASK = 8'b0011_1010;

    typedef struct packed {
        logic erase;
        logic prog;
        logic seq;
        logic volt;
        logic lock;
    } err_pulse_t;

    function automatic logic enters_status(input logic [7:0] code);
        return (code == CMD_RD_STATUS) || (code == CMD_PROGRAM) ||
               (code == CMD_ERASE)     || (code == CMD_LOCK);
    endfunction

    function automatic logic is_known(input logic [7:0] code);
        return enters_status(code) || (code == CMD_RD_ARRAY) ||
               (code == CMD_CLR_STAT);
    endfunction

endpackage

// File: rtl/fsr_cmd_decode.sv
module fsr_cmd_decode
    import fsr_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       cmd_wr,
    input  logic [7:0] cmd_code,
    output rd_mode_e   mode,
    output logic       clr_err
);

    rd_mode_e mode_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= MODE_ARRAY;
        end else if (cmd_wr) begin
            if (enters_status(cmd_code))
                mode_q <= MODE_STATUS;
            else if (cmd_code == CMD_RD_ARRAY)
                mode_q <= MODE_ARRAY;
        end
    end

    assign mode    = mode_q;
    assign clr_err = cmd_wr && (cmd_code == CMD_CLR_STAT);

    // R3
    program_to_status_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_wr && cmd_code == CMD_PROGRAM) |=> mode_q == MODE_STATUS);

    // R11
    unknown_cmd_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_wr && !is_known(cmd_code)) |=> $stable(mode_q));

endmodule

// File: rtl/fsr_status_reg.sv
module fsr_status_reg
    import fsr_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            busy,
    input  logic            ers_susp,
    input  logic            prg_susp,
    input  err_pulse_t      errs,
    input  logic            clr_err,
    output logic [SR_W-1:0] sr
);

    logic [SR_W-1:0] set_v;
    logic [SR_W-1:0] sticky_q;

    always_comb begin
        set_v              = '0;
        set_v[BIT_EFAIL]   = errs.erase | errs.seq;
        set_v[BIT_PFAIL]   = errs.prog  | errs.seq;
        set_v[BIT_VOLT]    = errs.volt;
        set_v[BIT_LOCKERR] = errs.lock;
    end

    for (genvar b = 0; b < SR_W; b++) begin : g_bit
        if (STICKY_MASK[b]) begin : g_sticky
            always_ff @(posedge clk) begin
                if (rst || clr_err)
                    sticky_q[b] <= 1'b0;
                else if (set_v[b])
                    sticky_q[b] <= 1'b1;
            end
        end else begin : g_live
            assign sticky_q[b] = 1'b0;
        end
    end

    always_comb begin
        sr            = sticky_q;
        sr[BIT_READY] = ~busy;
        sr[BIT_ESUSP] = ers_susp;
        sr[BIT_PSUSP] = prg_susp;
    end

    // R6
    efail_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (sticky_q[BIT_EFAIL] && !clr_err) |=> sticky_q[BIT_EFAIL]);

    // R6
    clear_drops_errors_chk: assert property (@(posedge clk) disable iff (rst)
        clr_err |=> (sticky_q & STICKY_MASK) == '0);

endmodule

// File: rtl/fsr_capture.sv
module fsr_capture
    import fsr_pkg::*;
#(
    parameter int unsigned OFF_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sync_mode,
    input  logic             ce_n,
    input  logic             oe_n,
    input  logic             adv_n,
    input  logic [OFF_W-1:0] word_off,
    input  logic [SR_W-1:0]  sr_in,
    output logic [SR_W-1:0]  snap,
    output logic [OFF_W-1:0] snap_off
);

    logic ce_q, oe_q, adv_q;
    logic async_cap, sync_cap, cap;
    logic [SR_W-1:0]  snap_q;
    logic [OFF_W-1:0] off_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ce_q  <= 1'b1;
            oe_q  <= 1'b1;
            adv_q <= 1'b1;
        end else begin
            ce_q  <= ce_n;
            oe_q  <= oe_n;
            adv_q <= adv_n;
        end
    end

    // first strobe fall after both were released
    assign async_cap = ce_q && oe_q && !(ce_n && oe_n);
    assign sync_cap  = (ce_q && !ce_n) || (adv_q && !adv_n);
    assign cap       = sync_mode ? sync_cap : async_cap;

    always_ff @(posedge clk) begin
        if (rst) begin
            snap_q <= SR_RESET;
            off_q  <= '0;
        end else if (cap) begin
            snap_q <= sr_in;
            off_q  <= word_off;
        end
    end

    assign snap     = snap_q;
    assign snap_off = off_q;

    // R7
    async_first_edge_chk: assert property (@(posedge clk) disable iff (rst)
        (!sync_mode && ce_q && oe_q && !(ce_n && oe_n)) |=> snap_q == $past(sr_in));

    // R8
    burst_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (sync_mode && !(ce_q && !ce_n) && !(adv_q && !adv_n)) |=> $stable(snap_q));

endmodule

// File: rtl/fsr_read_ctrl.sv
module fsr_read_ctrl
    import fsr_pkg::*;
#(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned OFF_W  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_wr,
    input  logic [7:0]        cmd_code,
    input  logic              busy,
    input  logic              ers_susp,
    input  logic              prg_susp,
    input  logic              err_erase,
    input  logic              err_prog,
    input  logic              err_seq,
    input  logic              err_volt,
    input  logic              err_lock,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              adv_n,
    input  logic              sync_mode,
    input  logic [OFF_W-1:0]  word_off,
    input  logic [DATA_W-1:0] arr_data,
    output logic [DATA_W-1:0] dq_o,
    output logic              dq_en
);

    localparam int unsigned PAD_W = DATA_W - SR_W;

    rd_mode_e         mode;
    logic             clr_err;
    err_pulse_t       errs;
    logic [SR_W-1:0]  sr_now;
    logic [SR_W-1:0]  snap;
    logic [OFF_W-1:0] snap_off;
    logic             word_ok;

    assign errs = '{erase: err_erase, prog: err_prog, seq: err_seq,
                    volt: err_volt, lock: err_lock};

    fsr_cmd_decode u_dec (
        .clk      (clk),
        .rst      (rst),
        .cmd_wr   (cmd_wr),
        .cmd_code (cmd_code),
        .mode     (mode),
        .clr_err  (clr_err)
    );

    fsr_status_reg u_sr (
        .clk      (clk),
        .rst      (rst),
        .busy     (busy),
        .ers_susp (ers_susp),
        .prg_susp (prg_susp),
        .errs     (errs),
        .clr_err  (clr_err),
        .sr       (sr_now)
    );

    fsr_capture #(.OFF_W(OFF_W)) u_cap (
        .clk      (clk),
        .rst      (rst),
        .sync_mode(sync_mode),
        .ce_n     (ce_n),
        .oe_n     (oe_n),
        .adv_n    (adv_n),
        .word_off (word_off),
        .sr_in    (sr_now),
        .snap     (snap),
        .snap_off (snap_off)
    );

    // in page reads only the captured word carries status
    assign word_ok = sync_mode || (word_off == snap_off);

    always_comb begin
        if (mode == MODE_STATUS)
            dq_o = word_ok ? {{PAD_W{1'b0}}, snap} : '0;
        else
            dq_o = arr_data;
    end

    assign dq_en = !ce_n && !oe_n;

    // R2
    status_upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_STATUS && dq_en) |-> dq_o[DATA_W-1:SR_W] == '0);

    // R10
    bus_release_chk: assert property (@(posedge clk) disable iff (rst)
        (ce_n || oe_n) |-> !dq_en);

endmodule

// File: tb/fsr_read_ctrl_test.sv
`timescale 1ns/1ps
module fsr_read_ctrl_test;

    localparam int VW = 44;
    localparam int NV = 47;
    localparam logic [15:0] ARR = 16'hBEEF;

    // {req, wr, cmd, busy, errs(e,p,s,v,l), susp(e,p), ctl(ce,oe,adv), sync, word, exp_en, exp_dq}
    localparam logic [VW-1:0] VECS [NV] = '{
        {4'd11,1'b1,8'h33,1'b0,5'b00000,2'b00,3'b111,1'b0,2'd0,1'b0,16'h0000}, // R11 unknown code
        {4'd11,1'b0,8'h00,1'b0,5'b00000,2'b00,3'b001,1'b0,2'd0,1'b1,16'hBEEF}, // R11 still array
        {4'd10,1'b0,8'h00,1'b0,5'b00000,2'b00,3'b111,1'b0,2'd0,1'b0,16'h0000},
        {4'd4, 1'b1,8'hA1,1'b0,5'b00000,2'b00,3'b111,1'b0,2'd0,1'b0,16'h0000}, // R4
        {4'd1, 1'b0,8'h00,1'b0,5'b00000,2'b00,3'b001,1'b0,2'd0,1'b1,16'h0080}, // R1 R2
        {4'd10,1'b0,8'h00,1'b0,5'b00000,2'b00,3'b111,1'b0,2'd0,1'b0,16'h0000},
        {4'd3, 1'b1,8'hA0,1'b0,5'b00000,2'b00,3'b111,1'b0,2'd0,1'b0,16'h0000}, // R3
        {4'd3, 1'b0,8'h00,1'b0,5'b00000,2'b00,3'b001,1'b0,2'd0,1'b1,16'hBEEF},
        {4'd10,1'b0,8'h00,1'b1,5'b00000,2'b00,3'b111,1'b0,2'd0,1'b0,16'h0000},
        {4'd3, 1'b1,8'hB0,1'b1,5'b00000,2'b00,3'b111,1'b0,2'd0,1'b0,16'h0000}, // R3 program
        {4'd5, 1'b0,8'h00,1'b1,5'b00000,2'b00,3'b001,1'b0,2'd0,1'b1,16'h0000}, // R5 busy
        {4'd7, 1'b0,8'h00,1'b0,5'b00000,2'b00,3'b001,1'b0,2'd0,1'b1,16'h0000}, // R7 held
        {4'd10,1'b0,8'h00,1'b0,5'b00000,2'b00,3'b011,1'b0,2'd0,1'b0,16'h0000},
        {4'd7, 1'b0,8'h00,1'b0,5'b00000,2'b00,3'b001,1'b0,2'd0,1'b1,16'h0000}, // R7 second edge
        {4'd10,1'b0,8'h00,1'b0,5'b00000,2'b00,3'b111,1'b0,2'd0,1'b0,16'h0000},
        {4'd10,1'b0,8'h00,1'b0,5'b00000,2'b00,3'b011,1'b0,2'd0,1'b0,16'h0000},
        {4'd7, 1'b0,8'h00,1'b0,5'b00000,2'b00,3'b001,1'b0,2'd0,1'b1,16'h0080}, // R7 ce first
        {4'd6, 1'b0,8'h00,1'b0,5'b01000,2'b00,3'b111,1'b0,2'd0,1'b0,16'h0000},
        {4'd10,1'b0,8'h00,1'b0,5'b00000,2'b00,3'b111,1'b0,2'd0,1'b0,16'h0000},
        {4'd6, 1'b0,8'h00,1'b0,5'b00000,2'b00,3'b001,1'b0,2'd0,1'b1,16'h0090}, // R6 prog fail
        {4'd6, 1'b0,8'h00,1'b0,5'b00100,2'b00,3'b111,1'b0,2'd0,1'b0,16'h0000},
        {4'd6, 1'b0,8'h00,1'b0,5'b00000,2'b00,3'b001,1'b0,2'd0,1'b1,16'h00B0}, // R6 seq
        {4'd6, 1'b0,8'h00,1'b0,5'b00011,2'b10,3'b111,1'b0,2'd0,1'b0,16'h0000},
        {4'd5, 1'b0,8'h00,1'b0,5'b00000,2'b10,3'b001,1'b0,2'd0,1'b1,16'h00FA}, // R5 R6
        {4'd6, 1'b1,8'hA2,1'b0,5'b00000,2'b00,3'b111,1'b0,2'd0,1'b0,16'h0000}, // R6 clear
        {4'd5, 1'b0,8'h00,1'b0,5'b00000,2'b01,3'b001,1'b0,2'd0,1'b1,16'h0084}, // R5 R6
        {4'd10,1'b0,8'h00,1'b0,5'b00000,2'b00,3'b111,1'b0,2'd0,1'b0,16'h0000},
        {4'd3, 1'b1,8'hB1,1'b0,5'b00000,2'b00,3'b111,1'b0,2'd0,1'b0,16'h0000}, // R3 erase
        {4'd9, 1'b0,8'h00,1'b0,5'b00000,2'b00,3'b001,1'b0,2'd0,1'b1,16'h0080}, // R9
        {4'd9, 1'b0,8'h00,1'b0,5'b00000,2'b00,3'b001,1'b0,2'd1,1'b1,16'h0000},
        {4'd9, 1'b0,8'h00,1'b0,5'b00000,2'b00,3'b001,1'b0,2'd0,1'b1,16'h0080},
        {4'd10,1'b0,8'h00,1'b0,5'b00000,2'b00,3'b111,1'b0,2'd0,1'b0,16'h0000},
        {4'd8, 1'b0,8'h00,1'b0,5'b00000,2'b00,3'b000,1'b1,2'd0,1'b1,16'h0080}, // R8
        {4'd8, 1'b0,8'h00,1'b1,5'b00000,2'b00,3'b001,1'b1,2'd0,1'b1,16'h0080},
        {4'd8, 1'b0,8'h00,1'b1,5'b00000,2'b00,3'b001,1'b1,2'd0,1'b1,16'h0080},
        {4'd8, 1'b0,8'h00,1'b1,5'b00000,2'b00,3'b000,1'b1,2'd0,1'b1,16'h0000},
        {4'd8, 1'b0,8'h00,1'b0,5'b00000,2'b00,3'b000,1'b1,2'd0,1'b1,16'h0000},
        {4'd8, 1'b0,8'h00,1'b0,5'b00000,2'b00,3'b001,1'b1,2'd0,1'b1,16'h0000},
        {4'd8, 1'b0,8'h00,1'b0,5'b00000,2'b00,3'b000,1'b1,2'd0,1'b1,16'h0080},
        {4'd10,1'b0,8'h00,1'b0,5'b00000,2'b00,3'b111,1'b0,2'd0,1'b0,16'h0000},
        {4'd3, 1'b1,8'hA0,1'b0,5'b00000,2'b00,3'b111,1'b0,2'd0,1'b0,16'h0000},
        {4'd3, 1'b0,8'h00,1'b0,5'b00000,2'b00,3'b001,1'b0,2'd0,1'b1,16'hBEEF},
        {4'd10,1'b0,8'h00,1'b0,5'b00000,2'b00,3'b111,1'b0,2'd0,1'b0,16'h0000},
        {4'd3, 1'b1,8'hB2,1'b0,5'b00000,2'b00,3'b111,1'b0,2'd0,1'b0,16'h0000}, // R3 lock
        {4'd3, 1'b0,8'h00,1'b0,5'b00000,2'b00,3'b001,1'b0,2'd0,1'b1,16'h0080},
        {4'd10,1'b0,8'h00,1'b0,5'b00000,2'b00,3'b011,1'b0,2'd0,1'b0,16'h0000}, // R10
        {4'd10,1'b0,8'h00,1'b0,5'b00000,2'b00,3'b101,1'b0,2'd0,1'b0,16'h0000}  // R10
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_wr = 1'b0;
    logic [7:0]  cmd_code = '0;
    logic        busy = 1'b0, ers_susp = 1'b0, prg_susp = 1'b0;
    logic        err_erase = 1'b0, err_prog = 1'b0, err_seq = 1'b0;
    logic        err_volt = 1'b0, err_lock = 1'b0;
    logic        ce_n = 1'b1, oe_n = 1'b1, adv_n = 1'b1;
    logic        sync_mode = 1'b0;
    logic [1:0]  word_off = '0;
    logic [15:0] arr_data = ARR;
    logic [15:0] dq_o;
    logic        dq_en;

    int n_checks = 0;
    int n_fail   = 0;

    always #2 clk = ~clk;

    fsr_read_ctrl uut (
        .clk(clk), .rst(rst), .cmd_wr(cmd_wr), .cmd_code(cmd_code),
        .busy(busy), .ers_susp(ers_susp), .prg_susp(prg_susp),
        .err_erase(err_erase), .err_prog(err_prog), .err_seq(err_seq),
        .err_volt(err_volt), .err_lock(err_lock),
        .ce_n(ce_n), .oe_n(oe_n), .adv_n(adv_n), .sync_mode(sync_mode),
        .word_off(word_off), .arr_data(arr_data),
        .dq_o(dq_o), .dq_en(dq_en)
    );

    task automatic check(input int req, input logic exp_en, input logic [15:0] exp_dq);
        n_checks++;
        if (dq_en !== exp_en || (exp_en && dq_o !== exp_dq)) begin
            n_fail++;
            $display("FAIL R%0d: dq_en=%b dq_o=%h expected dq_en=%b dq_o=%h",
                     req, dq_en, dq_o, exp_en, exp_dq);
        end
    endtask

    task automatic idle();
        cmd_wr = 0; cmd_code = '0; busy = 0; ers_susp = 0; prg_susp = 0;
        {err_erase, err_prog, err_seq, err_volt, err_lock} = '0;
        ce_n = 1; oe_n = 1; adv_n = 1; sync_mode = 0; word_off = '0;
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    initial begin
        #400000;
        n_fail++;
        $display("FAIL watchdog: run hung, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        check(10, 1'b0, 16'h0000); // R10 idle after reset

        for (int i = 0; i < NV; i++) begin
            logic [VW-1:0] v;
            v = VECS[i];
            cmd_wr   = v[39];
            cmd_code = v[38:31];
            busy     = v[30];
            {err_erase, err_prog, err_seq, err_volt, err_lock} = v[29:25];
            {ers_susp, prg_susp} = v[24:23];
            {ce_n, oe_n, adv_n}  = v[22:20];
            sync_mode = v[19];
            word_off  = v[18:17];
            step();
            check(int'(v[43:40]), v[16], v[15:0]);
        end

        // directed: erase fail alone sets bit 5 (R6)
        idle(); err_erase = 1; step();
        idle(); step();
        ce_n = 0; oe_n = 0; step();
        check(6, 1'b1, 16'h00A0); // R6
        idle(); step();

        // directed: reset mid-run restores array mode and clears flags (R1)
        err_prog = 1; step();
        idle(); rst = 1; step(); step();
        rst = 0; step();
        ce_n = 0; oe_n = 0; step();
        check(1, 1'b1, ARR); // R1 array mode after reset
        idle(); cmd_wr = 1; cmd_code = 8'hA1; step();
        idle(); step();
        ce_n = 0; oe_n = 0; step();
        check(1, 1'b1, 16'h0080); // R1 flags cleared
        // R2 upper byte zero even with all low bits set
        idle(); ers_susp = 1; prg_susp = 1; err_seq = 1; err_volt = 1; err_lock = 1; step();
        idle(); ers_susp = 1; prg_susp = 1; step();
        ce_n = 0; oe_n = 0; step();
        check(2, 1'b1, 16'h00FE); // R2
        idle(); step();

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule